// File: doc/BRIEF.md
# Position-Adaptive Replica Voter

This block sits between four reconfigurable processing zones and the per-sub-band output lanes. Each zone delivers one data word per cycle, and a run-time placement map states which sub-band, if any, each zone is currently running. Every sub-band is served by zero, one, two, three or four zones, in any combination of positions. The block groups the zones by sub-band and forwards one word per sub-band. A single copy passes straight through. Two or more copies are compared, and the word that a strict majority of the copies agree on is forwarded.

When copies disagree, the block blames physical zones, not sub-bands. With three or more copies, a zone that has no strict majority behind it is flagged. With two copies the culprit cannot be told apart, so both zones are flagged. A flag stays up until the reconfiguration side sends a clear pulse for that zone, which marks the zone as repaired. A zone that is flagged again after a repair is marked as permanently damaged, so that its work can be moved to another zone. All outputs are registered, one cycle after the inputs.

Top module: `adaptive_replica_voter`

## Requirements
- R1: The placement map carries a 3-bit code per zone, with zone z in bits [3z+2:3z]. Codes 1 to 4 name the sub-band. Code 0 and codes 5 to 7 mean the zone takes part in no group.
- R2: A sub-band held by exactly one zone outputs that zone's word one cycle later, with its valid bit high. Sub-band s is output on bits [8s-1:8s-8] and on valid bit s-1.
- R3: A sub-band held by no zone outputs valid low and a data word of zero.
- R4: In a three-copy group where two copies agree, the agreed word is output and only the dissenting zone is flagged.
- R5: In a three-copy group where all three words differ, all three zones are flagged, and the lowest-numbered zone's word is output.
- R6: In a two-copy group, differing words flag both zones and the lower-numbered zone's word is output. Equal words flag nothing.
- R7: A zone flag stays set until a clear pulse arrives for that zone. If a new fault and a clear arrive in the same cycle, the flag ends up set.
- R8: A zone that takes part in no group is never flagged, whatever its data.
- R9: A zone that is flagged after it has received at least one clear pulse gets its permanent-fault bit set. That bit stays set until reset.
- R10: Synchronous active-high reset zeroes all data, valid, flag and permanent-fault outputs.
- R11: In a four-copy group, a word held by at least three copies is output and the other zone is flagged. A two-against-two split flags all four zones and outputs zone 0's word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| zone_data_i | input | 32 | One word per zone, zone z in bits [8z+7:8z] |
| place_map_i | input | 12 | Sub-band code per zone, 3 bits each |
| fault_clr_i | input | 4 | Per-zone clear pulse, given when reconfiguration of that zone is done |
| sb_data_o | output | 32 | Voted word per sub-band, sub-band 1 in the low byte |
| sb_valid_o | output | 4 | Sub-band present in at least one zone |
| fault_flag_o | output | 4 | Sticky per-zone fault flags |
| perm_fault_o | output | 4 | Per-zone permanent-fault marks |

## Verification
The bench uses the default build: four zones, 8-bit words, 3-bit codes and four sub-bands. This width of code leaves the values 5 to 7 free, so the bench can check that unused codes are ignored. With four zones the bench can also place one sub-band in every zone, which makes both a three-against-one vote and a two-against-two split possible. The stimulus follows one flag history across clears, a fault that arrives in the same cycle as a clear, and later faults, so the permanent marks are checked against a known repair history.

// File: rtl/avote_pkg.sv
package avote_pkg;
  parameter int unsigned AV_ZONES    = 4;
  parameter int unsigned AV_DW       = 8;
  parameter int unsigned AV_CODE_W   = 3;
  parameter int unsigned AV_SUBBANDS = 4;
endpackage

// File: rtl/avote_group.sv
module avote_group #(
  parameter int unsigned NZONES = 4,
  parameter int unsigned DW     = 8,
  parameter int unsigned CW     = 3,
  parameter int unsigned SB_ID  = 1
) (
  input  logic [NZONES*DW-1:0] zone_data_i,
  input  logic [NZONES*CW-1:0] place_map_i,
  output logic [DW-1:0]        data_o,
  output logic                 present_o,
  output logic [NZONES-1:0]    bad_o
);
  logic [NZONES-1:0] member;
  int                cnt;
  int                agree [NZONES];

  always_comb begin
    cnt = 0;
    for (int z = 0; z < NZONES; z++) begin
      member[z] = (place_map_i[z*CW +: CW] == CW'(SB_ID));
      if (member[z]) cnt = cnt + 1;
    end
    for (int z = 0; z < NZONES; z++) begin
      agree[z] = 0;
      for (int j = 0; j < NZONES; j++) begin
        if (j != z && member[j] &&
            zone_data_i[j*DW +: DW] == zone_data_i[z*DW +: DW])
          agree[z] = agree[z] + 1;
      end
      bad_o[z] = member[z] && (cnt >= 2) && ((agree[z] + 1) * 2 <= cnt);
    end
    present_o = (cnt != 0);
    data_o    = '0;
    for (int z = NZONES - 1; z >= 0; z--)
      if (member[z]) data_o = zone_data_i[z*DW +: DW];
    for (int z = NZONES - 1; z >= 0; z--)
      if (member[z] && !bad_o[z]) data_o = zone_data_i[z*DW +: DW];
  end
endmodule

// File: rtl/avote_zone_flags.sv
module avote_zone_flags #(
  parameter int unsigned NZONES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NZONES-1:0] det_i,
  input  logic [NZONES-1:0] clr_i,
  output logic [NZONES-1:0] flag_o,
  output logic [NZONES-1:0] perm_o
);
  logic [NZONES-1:0] repaired_q;

  for (genvar z = 0; z < NZONES; z++) begin : g_zone
    always_ff @(posedge clk) begin
      if (rst) begin
        flag_o[z]     <= 1'b0;
        perm_o[z]     <= 1'b0;
        repaired_q[z] <= 1'b0;
      end else begin
        flag_o[z]     <= (flag_o[z] & ~clr_i[z]) | det_i[z];
        perm_o[z]     <= perm_o[z] | (det_i[z] & repaired_q[z]);
        repaired_q[z] <= repaired_q[z] | clr_i[z];
      end
    end
  end
endmodule

// File: rtl/adaptive_replica_voter.sv
module adaptive_replica_voter
  import avote_pkg::*;
#(
  parameter int unsigned NZONES    = AV_ZONES,
  parameter int unsigned DW        = AV_DW,
  parameter int unsigned CW        = AV_CODE_W,
  parameter int unsigned NSB       = AV_SUBBANDS
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NZONES*DW-1:0] zone_data_i,
  input  logic [NZONES*CW-1:0] place_map_i,
  input  logic [NZONES-1:0]    fault_clr_i,
  output logic [NSB*DW-1:0]    sb_data_o,
  output logic [NSB-1:0]       sb_valid_o,
  output logic [NZONES-1:0]    fault_flag_o,
  output logic [NZONES-1:0]    perm_fault_o
);
  logic [NSB-1:0][DW-1:0]     grp_data;
  logic [NSB-1:0]             grp_present;
  logic [NSB-1:0][NZONES-1:0] grp_bad;
  logic [NZONES-1:0]          det;

  for (genvar s = 0; s < NSB; s++) begin : g_sb
    avote_group #(
      .NZONES(NZONES), .DW(DW), .CW(CW), .SB_ID(s + 1)
    ) u_grp (
      .zone_data_i(zone_data_i),
      .place_map_i(place_map_i),
      .data_o     (grp_data[s]),
      .present_o  (grp_present[s]),
      .bad_o      (grp_bad[s])
    );
  end

  always_comb begin
    det = '0;
    for (int s = 0; s < NSB; s++) det = det | grp_bad[s];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sb_data_o  <= '0;
      sb_valid_o <= '0;
    end else begin
      sb_data_o  <= grp_data;
      sb_valid_o <= grp_present;
    end
  end

  avote_zone_flags #(.NZONES(NZONES)) u_flags (
    .clk   (clk),
    .rst   (rst),
    .det_i (det),
    .clr_i (fault_clr_i),
    .flag_o(fault_flag_o),
    .perm_o(perm_fault_o)
  );
endmodule

// File: rtl/avote_checker.sv
module avote_checker #(
  parameter int unsigned NZONES = 4,
  parameter int unsigned DW     = 8,
  parameter int unsigned CW     = 3,
  parameter int unsigned NSB    = 4
) (
  input logic                 clk,
  input logic                 rst,
  input logic [NZONES*DW-1:0] zone_data_i,
  input logic [NZONES*CW-1:0] place_map_i,
  input logic [NZONES-1:0]    fault_clr_i,
  input logic [NSB*DW-1:0]    sb_data_o,
  input logic [NSB-1:0]       sb_valid_o,
  input logic [NZONES-1:0]    fault_flag_o,
  input logic [NZONES-1:0]    perm_fault_o
);
  logic [NSB-1:0][NZONES-1:0] held;
  logic [NZONES-1:0]          idle;

  always_comb begin
    for (int z = 0; z < NZONES; z++) begin
      idle[z] = 1'b1;
      for (int s = 0; s < NSB; s++) begin
        held[s][z] = (place_map_i[z*CW +: CW] == CW'(s + 1));
        if (held[s][z]) idle[z] = 1'b0;
      end
    end
  end

  for (genvar z = 0; z < NZONES; z++) begin : g_z
    // R7: a flag without a clear pulse stays set
    a_r7_flag_sticky: assert property (@(posedge clk) disable iff (rst)
      fault_flag_o[z] && !fault_clr_i[z] |=> fault_flag_o[z]);
    // R9: permanent mark never drops
    a_r9_perm_sticky: assert property (@(posedge clk) disable iff (rst)
      perm_fault_o[z] |=> perm_fault_o[z]);
    // R9: a new permanent mark comes with a raised flag
    a_r9_perm_with_flag: assert property (@(posedge clk) disable iff (rst)
      $rose(perm_fault_o[z]) |-> fault_flag_o[z]);
    // R8: a zone outside every group cannot gain a flag
    a_r8_idle_unflagged: assert property (@(posedge clk) disable iff (rst)
      idle[z] && !fault_flag_o[z] |=> !fault_flag_o[z]);
  end

  for (genvar s = 0; s < NSB; s++) begin : g_s
    // R3: absent sub-band gives valid low and zero data
    a_r3_absent_zero: assert property (@(posedge clk) disable iff (rst)
      held[s] == '0 |=> !sb_valid_o[s] && sb_data_o[s*DW +: DW] == '0);
    for (genvar z = 0; z < NZONES; z++) begin : g_pz
      // R2: a lone copy passes through after one cycle
      a_r2_single_pass: assert property (@(posedge clk) disable iff (rst)
        held[s][z] && $countones(held[s]) == 1 |=>
          sb_valid_o[s] && sb_data_o[s*DW +: DW] == $past(zone_data_i[z*DW +: DW]));
    end
  end
endmodule

bind adaptive_replica_voter avote_checker #(
  .NZONES(NZONES), .DW(DW), .CW(CW), .NSB(NSB)
) u_chk (
  .clk(clk), .rst(rst), .zone_data_i(zone_data_i), .place_map_i(place_map_i),
  .fault_clr_i(fault_clr_i), .sb_data_o(sb_data_o), .sb_valid_o(sb_valid_o),
  .fault_flag_o(fault_flag_o), .perm_fault_o(perm_fault_o)
);

// File: tb/sim_adaptive_replica_voter.sv
module sim_adaptive_replica_voter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] zone_data = '0;
  logic [11:0] place_map = '0;
  logic [3:0]  clr = '0;
  logic [31:0] sb_data;
  logic [3:0]  sb_valid, flags, perm;
  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [31:0] d;
    logic [3:0]  v, f, p;
    string       tag;
  } exp_t;
  exp_t q[$];

  always #5 clk = ~clk;

  adaptive_replica_voter u0 (
    .clk(clk), .rst(rst), .zone_data_i(zone_data), .place_map_i(place_map),
    .fault_clr_i(clr), .sb_data_o(sb_data), .sb_valid_o(sb_valid),
    .fault_flag_o(flags), .perm_fault_o(perm)
  );

  function automatic logic [31:0] pk(input logic [7:0] a, b, c, d);
    return {d, c, b, a};
  endfunction
  function automatic logic [11:0] mp(input logic [2:0] a, b, c, d);
    return {d, c, b, a};
  endfunction

  task automatic chk(input logic ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic [11:0] m, input logic [31:0] d, input logic [3:0] c,
                      input logic [31:0] ed, input logic [3:0] ev, ef, ep,
                      input string tag);
    exp_t e;
    @(negedge clk);
    place_map = m; zone_data = d; clr = c;
    e.d = ed; e.v = ev; e.f = ef; e.p = ep; e.tag = tag;
    q.push_back(e);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        e = q.pop_front();
        chk(sb_data == e.d, e.tag, "data", sb_data, e.d);
        chk(sb_valid == e.v, e.tag, "valid", {28'd0, sb_valid}, {28'd0, e.v});
        chk(flags == e.f, e.tag, "flags", {28'd0, flags}, {28'd0, e.f});
        chk(perm == e.p, e.tag, "perm", {28'd0, perm}, {28'd0, e.p});
      end
    end
  end

  initial begin : watchdog
    #100000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : driver
    repeat (3) @(posedge clk);
    #2;
    chk({sb_data, sb_valid, flags, perm} == '0, "R10", "reset outputs",
        {sb_data[19:0], sb_valid, flags, perm}, 32'd0);
    @(negedge clk);
    rst = 1'b0;
    // R2: one sub-band per zone
    step(mp(1, 2, 3, 4), pk(8'h11, 8'h22, 8'h33, 8'h44), 4'b0000,
         pk(8'h11, 8'h22, 8'h33, 8'h44), 4'b1111, 4'b0000, 4'b0000, "R2");
    // R3/R8: only sub-band 2 present, unused zones carry data
    step(mp(2, 0, 0, 0), pk(8'hA0, 8'hB1, 8'hC2, 8'hD3), 4'b0000,
         pk(8'h00, 8'hA0, 8'h00, 8'h00), 4'b0010, 4'b0000, 4'b0000, "R3 R8");
    // R4: sub-band 3 in zones 0,1,3, zone 3 dissents
    step(mp(3, 3, 2, 3), pk(8'h5A, 8'h5A, 8'h77, 8'hC3), 4'b0000,
         pk(8'h00, 8'h77, 8'h5A, 8'h00), 4'b0110, 4'b1000, 4'b0000, "R4");
    // R7: flag holds when copies agree again
    step(mp(3, 3, 2, 3), pk(8'h5A, 8'h5A, 8'h77, 8'h5A), 4'b0000,
         pk(8'h00, 8'h77, 8'h5A, 8'h00), 4'b0110, 4'b1000, 4'b0000, "R7 hold");
    // R7: clear pulse drops flag
    step(mp(3, 3, 2, 3), pk(8'h5A, 8'h5A, 8'h77, 8'h5A), 4'b1000,
         pk(8'h00, 8'h77, 8'h5A, 8'h00), 4'b0110, 4'b0000, 4'b0000, "R7 clear");
    // R7: fault and clear in the same cycle on zone 0 -> set
    step(mp(3, 3, 2, 3), pk(8'h00, 8'h5A, 8'h77, 8'h5A), 4'b0001,
         pk(8'h00, 8'h77, 8'h5A, 8'h00), 4'b0110, 4'b0001, 4'b0000, "R7 set wins");
    // R5/R9: all three differ; zones 0 and 3 were repaired
    step(mp(3, 3, 2, 3), pk(8'h01, 8'h02, 8'h77, 8'h03), 4'b0000,
         pk(8'h00, 8'h77, 8'h01, 8'h00), 4'b0110, 4'b1011, 4'b1001, "R5 R9");
    // R6 match, R9 sticky: sub-band 1 in zones 1,2, clear all
    step(mp(0, 1, 1, 0), pk(8'hEE, 8'h40, 8'h40, 8'hFF), 4'b1111,
         pk(8'h40, 8'h00, 8'h00, 8'h00), 4'b0001, 4'b0000, 4'b1001, "R6 match");
    // R6 mismatch flags both, R9 marks the repaired pair
    step(mp(0, 1, 1, 0), pk(8'hEE, 8'h40, 8'h41, 8'hFF), 4'b0000,
         pk(8'h40, 8'h00, 8'h00, 8'h00), 4'b0001, 4'b0110, 4'b1111, "R6 R9");
    // R1: codes 5 and 7 are ignored
    step(mp(5, 4, 4, 7), pk(8'h12, 8'h99, 8'h99, 8'h34), 4'b0000,
         pk(8'h00, 8'h00, 8'h00, 8'h99), 4'b1000, 4'b0110, 4'b1111, "R1");
    // R11: four copies, three against one
    step(mp(2, 2, 2, 2), pk(8'h66, 8'h66, 8'h66, 8'h10), 4'b0000,
         pk(8'h00, 8'h66, 8'h00, 8'h00), 4'b0010, 4'b1110, 4'b1111, "R11 3v1");
    // R11: two against two
    step(mp(2, 2, 2, 2), pk(8'h20, 8'h20, 8'h30, 8'h30), 4'b0000,
         pk(8'h00, 8'h20, 8'h00, 8'h00), 4'b0010, 4'b1111, 4'b1111, "R11 2v2");
    @(negedge clk);
    clr = '0;
    wait (q.size() == 0);
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #2;
    chk({sb_data, sb_valid, flags, perm} == '0, "R10", "second reset",
        {sb_data[19:0], sb_valid, flags, perm}, 32'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule